// File: doc/BRIEF.md
# Single-Wire Bus Slot Timing Engine

This block is the master side of an open-drain single-wire bus. It turns a command into timed bus activity: a bus reset with presence detection, a single bit "touch" slot, or a whole byte sent or received one bit at a time, least significant bit first. The bus is seen as an output that pulls the line low when asserted, plus a raw line input. The raw input is resynchronised through a two-flop chain before use, and the sample instant allows for that latency.

All slot intervals are counted in microsecond ticks, which come in on an enable input. A delay multiplier stretches every interval by an integer factor. It is captured when a command is accepted, so changing it during a transfer has no effect. A command is accepted only while the engine is idle. It finishes with a one-cycle done pulse, and the result is then available on the result output.

A touch of 1 is a short low pulse followed by a sample of the line, so it serves as both a write-1 slot and a read slot. A touch of 0 holds the line low for most of the slot and always returns 0. The bus reset returns the sampled line level: 0 means a device answered and 1 means no device answered.

Top module: `owire_slot_engine`

## Requirements
- R1: A synchronous active-high reset releases the bus and clears busy and done before the next clock edge completes. This holds during a slot too, and no done pulse follows a reset taken mid-command.
- R2: Operation code 2'b00 is a bus reset. It pulls low for 480×M ticks, releases, samples the line 70×M ticks after release, and then waits 410×M ticks. Busy lasts 960×M ticks, and result bit 0 is the sampled level (0 means a device is present). The other result bits are 0.
- R3: Operation 2'b01 with data bit 0 = 1 is a touch-1 slot. It pulls low for 6×M ticks, samples 9×M ticks after release, and waits 55×M more ticks. Busy lasts 70×M ticks, and result bit 0 is the line level at the sample instant, with the synchroniser delay compensated.
- R4: Operation 2'b01 with data bit 0 = 0 is a touch-0 slot. It pulls low for 60×M ticks and releases for 10×M ticks. Result bit 0 is 0 whatever the line does.
- R5: M is the delay multiplier input captured at command accept, and a value of 0 is treated as 1. Changes to the multiplier while busy do not alter the running command.
- R6: Operation 2'b10 writes the data byte as eight back-to-back touch slots, bit 0 first. Each slot's type follows its data bit. The result gathers the eight touched bits, LSB first, and busy lasts 560×M ticks.
- R7: Operation 2'b11 reads a byte as eight touch-1 slots. The sampled bits are assembled LSB first, and busy lasts 560×M ticks.
- R8: Busy rises on the edge that accepts a command and falls on the edge that ends the last slot. On that same edge done rises for exactly one cycle. Commands presented while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick_i | input | 1 | One-cycle microsecond tick enable |
| delay_mult_i | input | MULT_W | Interval multiplier, 0 treated as 1 |
| cmd_valid_i | input | 1 | Command request, taken when not busy |
| cmd_op_i | input | 2 | 00 bus reset, 01 touch bit, 10 write byte, 11 read byte |
| cmd_data_i | input | BYTE_W | Byte to write, or bit 0 for a touch |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | BYTE_W | Presence, touched bit or byte; valid from done until the next accept |
| bus_pull_o | output | 1 | Pulls the bus low when high |
| bus_in_i | input | 1 | Raw bus line level |

## Verification
Every interval is measured in ticks that the engine actually consumes. The bench counts a tick at the falling edge that comes before the rising edge where the design samples it, and only while busy or the bus pull is high. Because of this, a slot's low time and the whole command length must match the required tick totals exactly. Done and the result are registered on the edge that consumes the last tick of the final slot, so the bench reads them at the following falling edge and checks that busy is already low there. A reset is checked one falling edge after it is applied. The ignored-command and missing-done checks allow a few extra cycles before they conclude.

// File: rtl/owire_pkg.sv
package owire_pkg;

    // command operation codes (values fixed by the command interface)
    typedef enum logic [1:0] {
        OP_BUSRST = 2'b00,
        OP_BIT    = 2'b01,
        OP_WRBYTE = 2'b10,
        OP_RDBYTE = 2'b11
    } op_e;

    // kinds of bus slot
    typedef enum logic [1:0] {
        SLOT_RST = 2'd0,
        SLOT_W0  = 2'd1,
        SLOT_W1  = 2'd2
    } slot_e;

    // phases inside one slot
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_GAP  = 2'd2,
        PH_REC  = 2'd3
    } phase_e;

endpackage

// File: rtl/owire_sync.sv
module owire_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    // an idle bus is high, so the chain resets to ones
    always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/owire_slot_fsm.sv
module owire_slot_fsm
    import owire_pkg::*;
#(
    parameter int MULT_W        = 4,
    parameter int US_W          = 10,
    parameter int SYNC_STAGES   = 2,
    parameter int T_RST_LOW     = 480,
    parameter int T_RST_SAMPLE  = 70,
    parameter int T_RST_REC     = 410,
    parameter int T_W1_LOW      = 6,
    parameter int T_W1_SAMPLE   = 9,
    parameter int T_W1_REC      = 55,
    parameter int T_W0_LOW      = 60,
    parameter int T_W0_REC      = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              start_i,
    input  slot_e             kind_i,
    input  logic [MULT_W-1:0] mult_i,
    input  logic              line_i,
    output logic              pull_o,
    output logic              last_o,
    output logic              bit_o,
    output logic              free_o
);

    localparam int CNT_W = US_W + MULT_W;

    typedef struct packed {
        phase_e                 phase;
        slot_e                  kind;
        logic [CNT_W-1:0]       cnt;
        logic [SYNC_STAGES-1:0] pend;
        logic                   smp;
    } slot_st_t;

    slot_st_t          st_d, st_q;
    logic [US_W-1:0]   base;
    logic [CNT_W-1:0]  lim;
    logic              ph_end;

    // base length of the current phase, in microseconds
    always_comb begin
        base = US_W'(1);
        case (st_q.kind)
            SLOT_RST: begin
                case (st_q.phase)
                    PH_LOW:  base = US_W'(T_RST_LOW);
                    PH_GAP:  base = US_W'(T_RST_SAMPLE);
                    PH_REC:  base = US_W'(T_RST_REC);
                    default: base = US_W'(1);
                endcase
            end
            SLOT_W0: begin
                case (st_q.phase)
                    PH_LOW:  base = US_W'(T_W0_LOW);
                    PH_REC:  base = US_W'(T_W0_REC);
                    default: base = US_W'(1);
                endcase
            end
            default: begin
                case (st_q.phase)
                    PH_LOW:  base = US_W'(T_W1_LOW);
                    PH_GAP:  base = US_W'(T_W1_SAMPLE);
                    PH_REC:  base = US_W'(T_W1_REC);
                    default: base = US_W'(1);
                endcase
            end
        endcase
        lim = CNT_W'(base) * CNT_W'(mult_i);
    end

    always_comb begin
        st_d   = st_q;
        ph_end = (st_q.phase != PH_IDLE) && tick_i && (st_q.cnt == lim - 1'b1);

        // delayed sample strobe: the synchroniser output catches up with
        // the line level of the nominal sample edge SYNC_STAGES cycles later
        st_d.pend = {st_q.pend[SYNC_STAGES-2:0], 1'b0};
        if (st_q.pend[SYNC_STAGES-1]) st_d.smp = line_i;

        if (tick_i && (st_q.phase != PH_IDLE)) st_d.cnt = st_q.cnt + 1'b1;

        if (ph_end) begin
            st_d.cnt = '0;
            case (st_q.phase)
                PH_LOW: st_d.phase = (st_q.kind == SLOT_W0) ? PH_REC : PH_GAP;
                PH_GAP: begin
                    st_d.phase   = PH_REC;
                    st_d.pend[0] = 1'b1;
                end
                default: st_d.phase = PH_IDLE;
            endcase
        end

        last_o = ph_end && (st_q.phase == PH_REC);
        free_o = (st_q.phase == PH_IDLE) || last_o;

        // a new slot may chain directly onto the end of the previous one
        if (start_i && free_o) begin
            st_d.phase = PH_LOW;
            st_d.kind  = kind_i;
            st_d.cnt   = '0;
            st_d.smp   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= PH_IDLE;
            st_q.kind  <= SLOT_W1;
            st_q.cnt   <= '0;
            st_q.pend  <= '0;
            st_q.smp   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pull_o = (st_q.phase == PH_LOW);
    assign bit_o  = st_q.smp;

    // R1
    bus_free_after_rst_chk: assert property (@(posedge clk)
        rst |=> !pull_o);

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase != PH_IDLE) |-> (st_q.cnt < lim));

    // R3
    sample_in_rec_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.pend[SYNC_STAGES-1] |-> (st_q.phase == PH_REC));

endmodule

// File: rtl/owire_byte_seq.sv
module owire_byte_seq
    import owire_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int MULT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid_i,
    input  logic [1:0]        cmd_op_i,
    input  logic [BYTE_W-1:0] cmd_data_i,
    input  logic [MULT_W-1:0] mult_i,
    input  logic              slot_last_i,
    input  logic              slot_bit_i,
    input  logic              slot_free_i,
    output logic              slot_start_o,
    output slot_e             slot_kind_o,
    output logic [MULT_W-1:0] slot_mult_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [BYTE_W-1:0] result_o
);

    localparam int                IDX_W    = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(BYTE_W - 1);

    typedef struct packed {
        logic              busy;
        logic              done;
        op_e               op;
        logic [BYTE_W-1:0] tx;
        logic [BYTE_W-1:0] res;
        logic [IDX_W-1:0]  idx;
        logic [MULT_W-1:0] mult;
    } seq_st_t;

    seq_st_t           seq_d, seq_q;
    op_e               op_in;
    logic [BYTE_W-1:0] tx_sel;
    logic              is_byte;

    always_comb begin
        seq_d        = seq_q;
        seq_d.done   = 1'b0;
        slot_start_o = 1'b0;
        slot_kind_o  = SLOT_W1;
        op_in        = op_e'(cmd_op_i);

        case (op_in)
            OP_BIT:    tx_sel = {{(BYTE_W-1){1'b0}}, cmd_data_i[0]};
            OP_WRBYTE: tx_sel = cmd_data_i;
            default:   tx_sel = '1;
        endcase

        is_byte = (seq_q.op == OP_WRBYTE) || (seq_q.op == OP_RDBYTE);

        if (cmd_valid_i && !seq_q.busy) begin
            seq_d.busy   = 1'b1;
            seq_d.op     = op_in;
            seq_d.tx     = tx_sel;
            seq_d.res    = '0;
            seq_d.idx    = '0;
            seq_d.mult   = (mult_i == '0) ? MULT_W'(1) : mult_i;
            slot_start_o = 1'b1;
            if (op_in == OP_BUSRST) slot_kind_o = SLOT_RST;
            else                    slot_kind_o = tx_sel[0] ? SLOT_W1 : SLOT_W0;
        end else if (seq_q.busy && slot_last_i) begin
            if (is_byte) seq_d.res = {slot_bit_i, seq_q.res[BYTE_W-1:1]};
            else         seq_d.res = {{(BYTE_W-1){1'b0}}, slot_bit_i};

            if (!is_byte || (seq_q.idx == LAST_IDX)) begin
                seq_d.busy = 1'b0;
                seq_d.done = 1'b1;
            end else begin
                seq_d.idx    = seq_q.idx + 1'b1;
                seq_d.tx     = {1'b0, seq_q.tx[BYTE_W-1:1]};
                slot_start_o = 1'b1;
                slot_kind_o  = seq_q.tx[1] ? SLOT_W1 : SLOT_W0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.busy <= 1'b0;
            seq_q.done <= 1'b0;
            seq_q.op   <= OP_BUSRST;
            seq_q.tx   <= '0;
            seq_q.res  <= '0;
            seq_q.idx  <= '0;
            seq_q.mult <= MULT_W'(1);
        end else begin
            seq_q <= seq_d;
        end
    end

    assign slot_mult_o = seq_q.mult;
    assign busy_o      = seq_q.busy;
    assign done_o      = seq_q.done;
    assign result_o    = seq_q.res;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_q.busy && !slot_last_i) |=> ($stable(seq_q.op) && $stable(seq_q.mult)));

    // R6
    start_when_free_chk: assert property (@(posedge clk) disable iff (rst)
        slot_start_o |-> slot_free_i);

endmodule

// File: rtl/owire_slot_engine.sv
module owire_slot_engine
    import owire_pkg::*;
#(
    parameter int BYTE_W        = 8,
    parameter int MULT_W        = 4,
    parameter int SYNC_STAGES   = 2,
    parameter int T_RST_LOW     = 480,
    parameter int T_RST_SAMPLE  = 70,
    parameter int T_RST_REC     = 410,
    parameter int T_W1_LOW      = 6,
    parameter int T_W1_SAMPLE   = 9,
    parameter int T_W1_REC      = 55,
    parameter int T_W0_LOW      = 60,
    parameter int T_W0_REC      = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              us_tick_i,
    input  logic [MULT_W-1:0] delay_mult_i,
    input  logic              cmd_valid_i,
    input  logic [1:0]        cmd_op_i,
    input  logic [BYTE_W-1:0] cmd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [BYTE_W-1:0] result_o,
    output logic              bus_pull_o,
    input  logic              bus_in_i
);

    // wide enough for the longest single interval
    localparam int US_W = $clog2(T_RST_LOW + T_RST_SAMPLE + T_RST_REC + 1);

    logic              line_sync;
    logic              slot_start, slot_last, slot_bit, slot_free;
    slot_e             slot_kind;
    logic [MULT_W-1:0] slot_mult;

    owire_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk (clk),
        .rst (rst),
        .d_i (bus_in_i),
        .q_o (line_sync)
    );

    owire_byte_seq #(
        .BYTE_W (BYTE_W),
        .MULT_W (MULT_W)
    ) i_seq (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid_i  (cmd_valid_i),
        .cmd_op_i     (cmd_op_i),
        .cmd_data_i   (cmd_data_i),
        .mult_i       (delay_mult_i),
        .slot_last_i  (slot_last),
        .slot_bit_i   (slot_bit),
        .slot_free_i  (slot_free),
        .slot_start_o (slot_start),
        .slot_kind_o  (slot_kind),
        .slot_mult_o  (slot_mult),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .result_o     (result_o)
    );

    owire_slot_fsm #(
        .MULT_W       (MULT_W),
        .US_W         (US_W),
        .SYNC_STAGES  (SYNC_STAGES),
        .T_RST_LOW    (T_RST_LOW),
        .T_RST_SAMPLE (T_RST_SAMPLE),
        .T_RST_REC    (T_RST_REC),
        .T_W1_LOW     (T_W1_LOW),
        .T_W1_SAMPLE  (T_W1_SAMPLE),
        .T_W1_REC     (T_W1_REC),
        .T_W0_LOW     (T_W0_LOW),
        .T_W0_REC     (T_W0_REC)
    ) i_fsm (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (us_tick_i),
        .start_i (slot_start),
        .kind_i  (slot_kind),
        .mult_i  (slot_mult),
        .line_i  (line_sync),
        .pull_o  (bus_pull_o),
        .last_o  (slot_last),
        .bit_o   (slot_bit),
        .free_o  (slot_free)
    );

endmodule

// File: tb/test_owire_slot_engine.sv
module test_owire_slot_engine;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 10;

    typedef struct packed {
        logic [1:0] op;
        logic [7:0] data;
        logic [3:0] mult;
        logic [7:0] pat;   // device reply per slot: bit k = 0 pulls low in slot k
        logic [7:0] exp;
        logic [7:0] req;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{2'b00, 8'h00, 4'd1, 8'hFE, 8'h00, 8'd2},  // R2 device present
        '{2'b00, 8'h00, 4'd2, 8'hFF, 8'h01, 8'd2},  // R2 no device, M=2
        '{2'b01, 8'h01, 4'd1, 8'hFF, 8'h01, 8'd3},  // R3 touch 1, line high
        '{2'b01, 8'h01, 4'd1, 8'hFE, 8'h00, 8'd3},  // R3 touch 1, device low
        '{2'b01, 8'h00, 4'd1, 8'hFF, 8'h00, 8'd4},  // R4 touch 0 reads 0
        '{2'b10, 8'hA5, 4'd1, 8'hFF, 8'hA5, 8'd6},  // R6 write byte
        '{2'b10, 8'h3C, 4'd1, 8'hF0, 8'h30, 8'd6},  // R6 write with contention
        '{2'b11, 8'h00, 4'd1, 8'h96, 8'h96, 8'd7},  // R7 read byte
        '{2'b11, 8'h00, 4'd2, 8'h01, 8'h01, 8'd7},  // R7 read byte, M=2
        '{2'b01, 8'h01, 4'd0, 8'hFF, 8'h01, 8'd5}   // R5 multiplier 0 acts as 1
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       us_tick = 1'b0;
    logic [1:0] tick_div = 2'd0;
    logic [3:0] dmult = 4'd1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [7:0] cmd_data = 8'h00;
    logic       busy, done, bus_pull, bus_in;
    logic [7:0] result;

    int   checks = 0;
    int   errors = 0;
    int   cyc_total = 0;

    // bench-side monitor and device model
    int   busy_ticks = 0;
    int   slot_n = 0;
    int   low_len [8];
    int   done_seen = 0;
    logic [7:0] res_cap = 8'h00;
    logic busy_at_done = 1'b0;
    logic pull_prev = 1'b0;
    logic dev_low = 1'b0;
    logic [7:0] dev_pat = 8'hFF;
    int   dev_idx = 0;

    assign bus_in = !(bus_pull || dev_low);

    owire_slot_engine i_owire_slot_engine (
        .clk          (clk),
        .rst          (rst),
        .us_tick_i    (us_tick),
        .delay_mult_i (dmult),
        .cmd_valid_i  (cmd_valid),
        .cmd_op_i     (cmd_op),
        .cmd_data_i   (cmd_data),
        .busy_o       (busy),
        .done_o       (done),
        .result_o     (result),
        .bus_pull_o   (bus_pull),
        .bus_in_i     (bus_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        tick_div <= tick_div + 2'd1;
        us_tick  <= (tick_div == 2'd3);
    end

    always @(negedge clk) begin
        if (bus_pull && !pull_prev) begin
            slot_n = slot_n + 1;
            if (slot_n <= 8) low_len[slot_n-1] = 0;
            dev_low = !dev_pat[dev_idx % 8];
            dev_idx = dev_idx + 1;
        end
        if (bus_pull && us_tick && slot_n >= 1 && slot_n <= 8)
            low_len[slot_n-1] = low_len[slot_n-1] + 1;
        pull_prev = bus_pull;
        if (busy && us_tick) busy_ticks = busy_ticks + 1;
        if (done) begin
            done_seen    = done_seen + 1;
            res_cap      = result;
            busy_at_done = busy;
        end
    end

    always @(posedge clk) begin
        cyc_total = cyc_total + 1;
        if (cyc_total > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired: actual %0d cycles, expected fewer", cyc_total);
            $display("  Simulation finished: %0d checks, %0d errors", checks + 1, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input int req, input string what,
                         input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL R%0d %s: actual %0d (0x%0h), expected %0d (0x%0h)",
                     req, what, act, act, exp, exp);
        end
    endtask

    task automatic clear_mon();
        busy_ticks = 0;
        slot_n     = 0;
        done_seen  = 0;
        dev_idx    = 0;
        dev_low    = 1'b0;
        for (int k = 0; k < 8; k++) low_len[k] = 0;
    endtask

    task automatic run_op(input logic [1:0] op, input logic [7:0] data,
                          input logic [3:0] mult, input logic [7:0] pat,
                          input int intrude, input logic [7:0] exp_res,
                          input int req);
        int cyc;
        int m;
        int exp_t;
        int exp_slots;
        int bad_low;
        int exp_low;
        @(negedge clk);
        clear_mon();
        dev_pat   = pat;
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_data  = data;
        dmult     = mult;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_data  = 8'h00;
        cyc = 0;
        while (done_seen == 0 && cyc < 40000) begin
            @(negedge clk);
            cyc = cyc + 1;
            if (intrude != 0 && cyc == intrude) begin
                // R8 command while busy; R5 multiplier change while busy
                cmd_valid = 1'b1;
                cmd_op    = 2'b11;
                dmult     = 4'd7;
            end else begin
                cmd_valid = 1'b0;
            end
        end
        repeat (4) @(negedge clk);

        m         = (mult == 4'd0) ? 1 : int'(mult);
        exp_t     = (op == 2'b00) ? 960*m : ((op == 2'b01) ? 70*m : 560*m);
        exp_slots = (op[1]) ? 8 : 1;
        bad_low   = 0;
        for (int k = 0; k < exp_slots; k++) begin
            if (op == 2'b00)      exp_low = 480*m;
            else if (op == 2'b11) exp_low = 6*m;
            else if (op == 2'b01) exp_low = data[0] ? 6*m : 60*m;
            else                  exp_low = data[k] ? 6*m : 60*m;
            if (low_len[k] != exp_low) bad_low = bad_low + 1;
        end

        check(done_seen == 1, 8, "done pulses per command (R8)", done_seen, 1);
        check(busy_at_done == 1'b0, 8, "busy low with done (R8)", int'(busy_at_done), 0);
        check(res_cap == exp_res, req, "result", int'(res_cap), int'(exp_res));
        check(busy_ticks == exp_t, req, "busy length in ticks", busy_ticks, exp_t);
        check(slot_n == exp_slots, req, "slot count", slot_n, exp_slots);
        check(bad_low == 0, req, "slot low widths, slot0 shown", low_len[0],
              (op == 2'b00) ? 480*m : ((op == 2'b01 && !data[0]) || (op == 2'b10 && !data[0])) ? 60*m : 6*m);
    endtask

    initial begin
        clear_mon();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(bus_pull == 1'b0, 1, "bus released in reset", int'(bus_pull), 0);
        check(busy == 1'b0, 1, "busy clear in reset", int'(busy), 0);
        check(done == 1'b0, 1, "done clear in reset", int'(done), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NVEC; v++)
            run_op(VEC[v].op, VEC[v].data, VEC[v].mult, VEC[v].pat, 0,
                   VEC[v].exp, int'(VEC[v].req));

        // R8 and R5: command and multiplier change while busy are ignored
        run_op(2'b01, 8'h01, 4'd1, 8'hFF, 20, 8'h01, 8);
        // R5 latched multiplier on a byte read; the intruder raises it to 7
        run_op(2'b11, 8'h00, 4'd3, 8'h5A, 100, 8'h5A, 5);

        // R1 synchronous reset in the middle of a bus reset
        @(negedge clk);
        clear_mon();
        dev_pat   = 8'hFF;
        cmd_valid = 1'b1;
        cmd_op    = 2'b00;
        dmult     = 4'd1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (100) @(negedge clk);
        check(bus_pull == 1'b1, 2, "bus pulled during reset low phase", int'(bus_pull), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(bus_pull == 1'b0, 1, "bus released after mid-slot reset", int'(bus_pull), 0);
        check(busy == 1'b0, 1, "busy cleared after mid-slot reset", int'(busy), 0);
        repeat (4500) @(negedge clk);
        check(done_seen == 0, 1, "no done after mid-slot reset", done_seen, 0);
        check(bus_pull == 1'b0, 1, "bus stays released", int'(bus_pull), 0);

        // engine usable again after the reset: R4 touch 0 against a low device
        run_op(2'b01, 8'h00, 4'd1, 8'h00, 0, 8'h00, 4);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule